// File: doc/BRIEF.md
# Stored-Program Processor Control Sequencer

This block is the finite-state controller of a small accumulator-style processor that keeps program and data in one memory. It takes an 8-bit opcode from the instruction register and the four condition-code flags (negative, zero, overflow, carry). From these it drives the select lines of the two datapath buses, the register load strobes, the program-counter increment, the ALU function and the memory write strobe.

Every instruction begins with the same two fetch cycles. The first copies the program counter into the memory address register. The second loads the opcode into the instruction register and advances the program counter. A decode cycle follows, whose outputs depend on the opcode. Each supported opcode then runs its own execute state and goes back to fetch.

Two instructions are built in. The first loads X from the immediate byte that follows the opcode. The second adds Y to X through the ALU operand register and updates the flags. Any other opcode ends the instruction at decode without touching anything. All outputs are combinational in the current state and the opcode. Each load takes effect at the clock edge that leaves the cycle in which it is asserted.

Top module: `sp_ctrl_unit`

## Requirements
- R1: While rst_ni is low, every strobe is low, both bus selects are 0 and the ALU function is 0. This holds at once, even in the middle of an instruction. In the first cycle after release the outputs are those of the first fetch cycle.
- R2: First fetch cycle: bus1 select = 0 (PC), bus2 select = 0 (pass bus1), the MAR load strobe is high and every other strobe is low.
- R3: Second fetch cycle, which always follows the first: bus2 select = 2 (memory output), the IR load and PC increment strobes are high, and the other strobes are low.
- R4: Decode cycle with opcode 0x86 (load X immediate): bus1 = 0 (PC), bus2 = 0, and only the MAR load strobe is high.
- R5: The cycle after a 0x86 decode: bus2 = 2 (memory output), and the X load and PC increment strobes are high.
- R6: Decode cycle with opcode 0x42 (add Y to X): bus1 = 1 (X), bus2 = 0, and only the ALU operand register load is high.
- R7: The cycle after a 0x42 decode: bus1 = 2 (Y), bus2 = 1 (ALU result), ALU function = 1 (ADD), and the X load and flag load strobes are high.
- R8: The cycle after the last execute cycle of an instruction is a first fetch cycle.
- R9: Any opcode other than 0x86 and 0x42, including the near misses 0x87 and 0x43, makes the decode cycle assert no strobe, and the next cycle is a first fetch cycle.
- R10: At most one of the loads fed from bus2 (MAR, IR, X, Y, ALU operand) is high in any cycle.
- R11: The condition-code inputs do not change the sequence or the outputs. The Y load and memory write strobes are never asserted.
- R12: The ALU function is 0 (pass) in every cycle except the add execute cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_i | input | 8 | Opcode held in the instruction register |
| ccr_i | input | 4 | Condition flags N,Z,V,C |
| bus1_sel_o | output | 2 | Bus1 source: 0 PC, 1 X, 2 Y |
| bus2_sel_o | output | 2 | Bus2 source: 0 bus1, 1 ALU, 2 memory |
| mar_ld_o | output | 1 | Load memory address register |
| ir_ld_o | output | 1 | Load instruction register |
| x_ld_o | output | 1 | Load X |
| y_ld_o | output | 1 | Load Y |
| opnd_ld_o | output | 1 | Load ALU operand register |
| ccr_ld_o | output | 1 | Load condition flags |
| pc_inc_o | output | 1 | Increment program counter |
| alu_op_o | output | 3 | ALU function: 0 pass, 1 add |
| mem_wr_o | output | 1 | Memory write strobe |

## Verification
The bench runs load and add instructions back to back and checks every cycle. A controller that skipped the return to fetch, or dropped the second PC increment in the load path, would put the wrong outputs in the following cycle. Opcodes one bit away from the valid ones (0x87, 0x43) and other unknown values must end the instruction at decode. A loose opcode compare would instead show execute strobes. Flag values are varied to catch any dependence on them, and a reset applied during the add execute cycle must clear the X and flag loads at once rather than at the next edge.

// File: rtl/sp_ctrl_pkg.sv
package sp_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_FETCH0 = 3'd0,
    ST_FETCH1 = 3'd1,
    ST_DECODE = 3'd2,
    ST_LDX_EX = 3'd3,
    ST_ADD_EX = 3'd4
  } state_e;

  typedef enum logic [1:0] {
    B1_PC = 2'd0,
    B1_X  = 2'd1,
    B1_Y  = 2'd2
  } bus1_e;

  typedef enum logic [1:0] {
    B2_BUS1 = 2'd0,
    B2_ALU  = 2'd1,
    B2_MEM  = 2'd2
  } bus2_e;

  typedef enum logic [2:0] {
    ALU_PASS = 3'd0,
    ALU_ADD  = 3'd1
  } alu_e;

  typedef enum logic [1:0] {
    IC_NONE = 2'd0,
    IC_LDX  = 2'd1,
    IC_ADD  = 2'd2
  } iclass_e;

  typedef struct packed {
    bus1_e b1;
    bus2_e b2;
    logic  mar_ld;
    logic  ir_ld;
    logic  x_ld;
    logic  y_ld;
    logic  opnd_ld;
    logic  ccr_ld;
    logic  pc_inc;
    logic  mem_wr;
    alu_e  alu;
  } ctrl_t;

endpackage

// File: rtl/sp_ctrl_dec.sv
module sp_ctrl_dec
  import sp_ctrl_pkg::*;
#(
  parameter int unsigned         OPC_W   = 8,
  parameter logic [OPC_W-1:0]    OPC_LDX = 8'h86,
  parameter logic [OPC_W-1:0]    OPC_ADD = 8'h42
) (
  input  logic [OPC_W-1:0] opc_i,
  output iclass_e          cls_o
);

  // exact full-width match only
  always_comb begin
    if (opc_i == OPC_LDX)      cls_o = IC_LDX;
    else if (opc_i == OPC_ADD) cls_o = IC_ADD;
    else                       cls_o = IC_NONE;
  end

endmodule

// File: rtl/sp_ctrl_seq.sv
module sp_ctrl_seq
  import sp_ctrl_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  iclass_e cls_i,
  output state_e  state_o
);

  state_e state_q, state_d;

  always_comb begin
    state_d = ST_FETCH0;
    unique case (state_q)
      ST_FETCH0: state_d = ST_FETCH1;
      ST_FETCH1: state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (cls_i)
          IC_LDX:  state_d = ST_LDX_EX;
          IC_ADD:  state_d = ST_ADD_EX;
          default: state_d = ST_FETCH0;
        endcase
      end
      default:   state_d = ST_FETCH0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  a_r3_fetch_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FETCH0 |=> state_q == ST_FETCH1);

  a_r8_exec_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LDX_EX || state_q == ST_ADD_EX) |=> state_q == ST_FETCH0);

  a_r9_bad_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECODE && cls_i == IC_NONE) |=> state_q == ST_FETCH0);

endmodule

// File: rtl/sp_ctrl_out.sv
module sp_ctrl_out
  import sp_ctrl_pkg::*;
(
  input  logic    rst_ni,
  input  state_e  state_i,
  input  iclass_e cls_i,
  output ctrl_t   ctrl_o
);

  ctrl_t c;

  always_comb begin
    c = '0;
    unique case (state_i)
      ST_FETCH0: begin
        c.b1     = B1_PC;
        c.b2     = B2_BUS1;
        c.mar_ld = 1'b1;
      end
      ST_FETCH1: begin
        c.b2     = B2_MEM;
        c.ir_ld  = 1'b1;
        c.pc_inc = 1'b1;
      end
      ST_DECODE: begin
        unique case (cls_i)
          IC_LDX: begin
            c.b1     = B1_PC;
            c.b2     = B2_BUS1;
            c.mar_ld = 1'b1;
          end
          IC_ADD: begin
            c.b1      = B1_X;
            c.b2      = B2_BUS1;
            c.opnd_ld = 1'b1;
          end
          default: c = '0;
        endcase
      end
      ST_LDX_EX: begin
        c.b2     = B2_MEM;
        c.x_ld   = 1'b1;
        c.pc_inc = 1'b1;
      end
      ST_ADD_EX: begin
        c.b1     = B1_Y;
        c.b2     = B2_ALU;
        c.alu    = ALU_ADD;
        c.x_ld   = 1'b1;
        c.ccr_ld = 1'b1;
      end
      default: c = '0;
    endcase
    // strobes held quiet for the whole reset window
    ctrl_o = rst_ni ? c : '0;
  end

endmodule

// File: rtl/sp_ctrl_unit.sv
module sp_ctrl_unit
  import sp_ctrl_pkg::*;
#(
  parameter int unsigned      OPC_W   = 8,
  parameter logic [OPC_W-1:0] OPC_LDX = 8'h86,
  parameter logic [OPC_W-1:0] OPC_ADD = 8'h42,
  parameter int unsigned      FLAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OPC_W-1:0]  ir_i,
  input  logic [FLAG_W-1:0] ccr_i,
  output logic [1:0]        bus1_sel_o,
  output logic [1:0]        bus2_sel_o,
  output logic              mar_ld_o,
  output logic              ir_ld_o,
  output logic              x_ld_o,
  output logic              y_ld_o,
  output logic              opnd_ld_o,
  output logic              ccr_ld_o,
  output logic              pc_inc_o,
  output logic [2:0]        alu_op_o,
  output logic              mem_wr_o
);

  iclass_e cls;
  state_e  state;
  ctrl_t   ctrl;

  // flags reach no decision with the current opcode set
  logic unused_ccr;
  assign unused_ccr = ^ccr_i;

  sp_ctrl_dec #(
    .OPC_W   (OPC_W),
    .OPC_LDX (OPC_LDX),
    .OPC_ADD (OPC_ADD)
  ) u_dec (
    .opc_i (ir_i),
    .cls_o (cls)
  );

  sp_ctrl_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cls_i   (cls),
    .state_o (state)
  );

  sp_ctrl_out u_out (
    .rst_ni  (rst_ni),
    .state_i (state),
    .cls_i   (cls),
    .ctrl_o  (ctrl)
  );

  assign bus1_sel_o = ctrl.b1;
  assign bus2_sel_o = ctrl.b2;
  assign mar_ld_o   = ctrl.mar_ld;
  assign ir_ld_o    = ctrl.ir_ld;
  assign x_ld_o     = ctrl.x_ld;
  assign y_ld_o     = ctrl.y_ld;
  assign opnd_ld_o  = ctrl.opnd_ld;
  assign ccr_ld_o   = ctrl.ccr_ld;
  assign pc_inc_o   = ctrl.pc_inc;
  assign alu_op_o   = ctrl.alu;
  assign mem_wr_o   = ctrl.mem_wr;

  a_r10_one_bus2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mar_ld_o, ir_ld_o, x_ld_o, y_ld_o, opnd_ld_o}));

  a_r12_alu_only_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_op_o != 3'd0 |-> (ccr_ld_o && bus2_sel_o == 2'd1));

  a_r5_ldx_fetch_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DECODE && cls == IC_LDX) |=> (x_ld_o && pc_inc_o && bus2_sel_o == 2'd2));

  a_r7_add_after_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DECODE && cls == IC_ADD) |=> (x_ld_o && ccr_ld_o && alu_op_o == 3'd1));

endmodule

// File: tb/sp_ctrl_unit_bench.sv
`timescale 1ns/1ps
module sp_ctrl_unit_bench;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] ir = 8'h00;
  logic [3:0] ccr = 4'h0;
  logic [1:0] b1, b2;
  logic       mar_ld, ir_ld, x_ld, y_ld, opnd_ld, ccr_ld, pc_inc, mem_wr;
  logic [2:0] alu;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sp_ctrl_unit u_sp_ctrl_unit (
    .clk_i(clk), .rst_ni(rst_ni), .ir_i(ir), .ccr_i(ccr),
    .bus1_sel_o(b1), .bus2_sel_o(b2),
    .mar_ld_o(mar_ld), .ir_ld_o(ir_ld), .x_ld_o(x_ld), .y_ld_o(y_ld),
    .opnd_ld_o(opnd_ld), .ccr_ld_o(ccr_ld), .pc_inc_o(pc_inc),
    .alu_op_o(alu), .mem_wr_o(mem_wr)
  );

  // {b1,b2,mar,ir,x,y,opnd,ccr,pc,wr,alu}
  localparam logic [14:0] F0 = {2'd0, 2'd0, 8'b1000_0000, 3'd0};
  localparam logic [14:0] F1 = {2'd0, 2'd2, 8'b0100_0010, 3'd0};
  localparam logic [14:0] DL = {2'd0, 2'd0, 8'b1000_0000, 3'd0};
  localparam logic [14:0] EL = {2'd0, 2'd2, 8'b0010_0010, 3'd0};
  localparam logic [14:0] DA = {2'd1, 2'd0, 8'b0000_1000, 3'd0};
  localparam logic [14:0] EA = {2'd2, 2'd1, 8'b0010_0100, 3'd1};
  localparam logic [14:0] QZ = 15'd0;

  localparam int NV = 29;
  // {ir, ccr, req, expected}
  localparam logic [30:0] VEC [NV] = '{
    {8'h86, 4'h0, 4'd2,  F0}, {8'h86, 4'h0, 4'd3,  F1},  // R2 R3
    {8'h86, 4'h0, 4'd4,  DL}, {8'h86, 4'h0, 4'd5,  EL},  // R4 R5
    {8'h86, 4'h0, 4'd8,  F0}, {8'h42, 4'h0, 4'd3,  F1},  // R8
    {8'h42, 4'h0, 4'd6,  DA}, {8'h42, 4'h0, 4'd7,  EA},  // R6 R7
    {8'h42, 4'h0, 4'd8,  F0}, {8'h00, 4'h0, 4'd3,  F1},
    {8'h00, 4'h0, 4'd9,  QZ}, {8'h00, 4'h0, 4'd9,  F0},  // R9
    {8'h42, 4'hF, 4'd11, F1}, {8'h42, 4'hF, 4'd11, DA},  // R11 flags set
    {8'h42, 4'hF, 4'd11, EA}, {8'h86, 4'hA, 4'd8,  F0},
    {8'h86, 4'hA, 4'd11, F1}, {8'h86, 4'hA, 4'd11, DL},
    {8'h86, 4'hA, 4'd11, EL}, {8'h87, 4'h0, 4'd2,  F0},
    {8'h87, 4'h0, 4'd3,  F1}, {8'h87, 4'h0, 4'd9,  QZ},  // near miss
    {8'h43, 4'h5, 4'd2,  F0}, {8'h43, 4'h5, 4'd3,  F1},
    {8'h43, 4'h5, 4'd9,  QZ}, {8'hFF, 4'h0, 4'd2,  F0},
    {8'hFF, 4'h0, 4'd3,  F1}, {8'hFF, 4'h0, 4'd9,  QZ},
    {8'hFF, 4'h0, 4'd8,  F0}
  };

  function automatic logic [14:0] outs();
    return {b1, b2, mar_ld, ir_ld, x_ld, y_ld, opnd_ld, ccr_ld, pc_inc, mem_wr, alu};
  endfunction

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 quiet in reset
    repeat (3) @(negedge clk);
    #1 check("R1", outs(), QZ);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (i != 0) @(negedge clk);
      ir  = VEC[i][30:23];
      ccr = VEC[i][22:19];
      #1;
      check($sformatf("R%0d", VEC[i][18:15]), outs(), VEC[i][14:0]);
      // R10 at most one bus2 load, R12 pass unless add execute
      check("R10", {14'd0, ($countones({mar_ld, ir_ld, x_ld, y_ld, opnd_ld}) > 1)}, 15'd0);
      check("R12", {12'd0, alu}, {12'd0, VEC[i][2:0]});
      check("R11", {13'd0, y_ld, mem_wr}, 15'd0);
    end

    // reset during add execute: R1
    @(negedge clk); ir = 8'h42; #1 check("R3", outs(), F1);
    @(negedge clk); #1 check("R6", outs(), DA);
    @(negedge clk); #1 check("R7", outs(), EA);
    rst_ni = 1'b0;
    #0.5 check("R1", outs(), QZ);
    @(negedge clk); #1 check("R1", outs(), QZ);
    rst_ni = 1'b1;
    #0.5 check("R1", outs(), F0);
    @(negedge clk); #1 check("R3", outs(), F1);
    @(negedge clk); #1 check("R6", outs(), DA);

    finish_run();
  end

endmodule